// File: doc/BRIEF.md
# Field Shift-and-Mask Unit

This block extracts a bit field from a pair of words, or merges a field into one of them. A control register holds a packed descriptor with three parts: a shift distance, a mask width and a mode flag.

When the start strobe is seen, the unit does the following in one cycle:
- It joins the left and right operands into a double-width word, left in the upper half.
- It shifts that word left by the shift distance and keeps the upper half.
- It builds a mask of low-order ones, as many as the mask width.
- In extract mode it returns the masked shifted value.
- In insert mode it fills the unmasked positions from the right operand instead of with zeros.

The descriptor is loaded before the operation through its own write strobe. Shift and mask widths each run from 0 to the word width. A mask of full width makes the unit a plain funnel shifter. A shift of zero makes it a plain mask applied to the left operand.

Top module: `field_unit`

## Requirements
- R1: After reset the result output is zero and the held descriptor is zero.
- R2: When `desc_we` is high at a rising edge, the descriptor register takes `desc_in`. The fields are: shift distance in bits 5:0, mask width in bits 11:6, and the insert flag in bit 12 (1 = insert, 0 = extract).
- R3: The shifted value is the upper 32 bits of {left_op, right_op} shifted left by the shift distance. A shift of 0 gives left_op and a shift of 32 gives right_op.
- R4: The mask has ones in bit positions 0 to width−1 and zeros above. A width of 0 gives an all-zero mask and a width of 32 gives an all-ones mask.
- R5: In extract mode the result is the shifted value AND the mask.
- R6: In insert mode the result is (shifted value AND mask) OR (right_op AND NOT mask). This holds at the corners mask 0, mask 32 and shift 32.
- R7: A shift or mask field value above 32 behaves exactly as 32.
- R8: The result register updates on the rising edge where `start` is high. On edges where `start` is low, the result holds its value whatever the operands do.
- R9: An operation started on the same edge as a descriptor write uses the descriptor held before that write. The new descriptor applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_we | input | 1 | Descriptor write strobe |
| desc_in | input | 13 | Packed descriptor to load |
| start | input | 1 | Launch an operation with the current operands |
| left_op | input | 32 | Upper operand of the funnel |
| right_op | input | 32 | Lower operand of the funnel, also the insert background |
| result | output | 32 | Registered field result |

## Verification
The properties read the held descriptor at the edge where `start` is high. They also assume the operands are stable around that edge, so that `$past` of an operand is the value the unit consumed. The stimulus changes operands and descriptor only at falling edges and keeps `start` at least half a cycle ahead of the edge it targets. Descriptor values above 32 in either field are driven on purpose, because the clamp properties must hold there as well.

// File: rtl/field_unit.sv
module field_unit #(
  parameter  int W  = 32,
  localparam int SW = $clog2(W + 1),
  localparam int DW = 2 * SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_we,
  input  logic [DW-1:0] desc_in,
  input  logic          start,
  input  logic [W-1:0]  left_op,
  input  logic [W-1:0]  right_op,
  output logic [W-1:0]  result
);

  logic [DW-1:0]  desc_q;
  logic [SW-1:0]  sh_raw, mk_raw, sh, mk;
  logic           ins;
  logic [2*W-1:0] funnel;
  logic [W-1:0]   shifted, mask, nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       desc_q <= '0;
    else if (desc_we) desc_q <= desc_in;

  assign sh_raw = desc_q[SW-1:0];
  assign mk_raw = desc_q[2*SW-1:SW];
  assign ins    = desc_q[2*SW];

  assign sh = (sh_raw > SW'(W)) ? SW'(W) : sh_raw;
  assign mk = (mk_raw > SW'(W)) ? SW'(W) : mk_raw;

  assign funnel  = {left_op, right_op} << sh;
  assign shifted = funnel[2*W-1:W];
  assign mask    = ~({W{1'b1}} << mk);

  assign nxt = ins ? ((shifted & mask) | (right_op & ~mask)) : (shifted & mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     result <= '0;
    else if (start) result <= nxt;

endmodule

module field_unit_chk #(
  parameter int W  = 32,
  parameter int SW = 6,
  parameter int DW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [W-1:0]  left_op,
  input logic [W-1:0]  right_op,
  input logic [DW-1:0] desc_q,
  input logic [W-1:0]  result
);
  logic [SW-1:0] c_sh, c_mk;
  logic          c_ins;
  assign c_sh  = desc_q[SW-1:0];
  assign c_mk  = desc_q[2*SW-1:SW];
  assign c_ins = desc_q[2*SW];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result)); // R8
  AST_PURE_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start && !c_ins && c_sh == 0 && c_mk >= SW'(W) |=> result == $past(left_op)); // R3
  AST_PURE_SHIFT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    start && !c_ins && c_sh >= SW'(W) && c_mk >= SW'(W) |=> result == $past(right_op)); // R7
  AST_EXTRACT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !c_ins && c_mk == 0 |=> result == '0); // R5
  AST_INSERT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    start && c_ins && c_mk == 0 |=> result == $past(right_op)); // R6
  AST_MASK_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !c_ins && c_sh == 0 && c_mk < SW'(W) |=> (result >> c_mk) == '0); // R4
endmodule

bind field_unit field_unit_chk #(.W(W), .SW(SW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .left_op(left_op),
  .right_op(right_op), .desc_q(desc_q), .result(result));

// File: tb/sim_field_unit.sv
module sim_field_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_we = 1'b0;
  logic [12:0] desc_in = '0;
  logic        start = 1'b0;
  logic [31:0] left_op = '0, right_op = '0;
  logic [31:0] result;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        armed = 1'b0;

  always #10 clk = ~clk;

  field_unit u0 (.clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_in(desc_in),
                 .start(start), .left_op(left_op), .right_op(right_op), .result(result));

  function automatic logic [12:0] pack(input bit ins, input int mk, input int sh);
    return 13'(ins) * 13'd4096 + 13'(mk) * 13'd64 + 13'(sh);
  endfunction

  function automatic logic [31:0] model(input logic [12:0] d, input logic [31:0] l, input logic [31:0] r);
    int sh, mk, src;
    logic [31:0] o;
    sh = int'(d[5:0]);  if (sh > 32) sh = 32;
    mk = int'(d[11:6]); if (mk > 32) mk = 32;
    for (int i = 0; i < 32; i++) begin
      src = i + 32 - sh;
      if (i < mk) o[i] = (src >= 32) ? l[src-32] : r[src];
      else        o[i] = d[12] ? r[i] : 1'b0;
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) armed <= start;
  always @(negedge clk)
    if (armed) begin
      if (exp_q.size() == 0) check("R8 unexpected result", result, 32'hx);
      else check(tag_q.pop_front(), result, exp_q.pop_front());
    end

  task automatic run_op(input string req, input logic [12:0] d, input logic [31:0] l, input logic [31:0] r);
    desc_we = 1'b1; desc_in = d;
    @(negedge clk);
    desc_we = 1'b0;
    start = 1'b1; left_op = l; right_op = r;
    exp_q.push_back(model(d, l, r)); tag_q.push_back(req);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (2) @(negedge clk);
    check("R1 reset result", result, 32'h0);
    rst_n = 1'b1;
    // R1: descriptor zero after reset -> extract, mask 0, result 0
    @(negedge clk);
    start = 1'b1; left_op = 32'hFFFFFFFF; right_op = 32'hFFFFFFFF;
    exp_q.push_back(32'h0); tag_q.push_back("R1 reset descriptor");
    @(negedge clk); start = 1'b0; @(negedge clk);

    for (int s = 0; s <= 32; s++) run_op("R3 shift sweep", pack(0, 32, s), 32'hF0402010, 32'hAAAAAAAA);
    for (int m = 0; m <= 32; m++) run_op("R4 mask sweep", pack(0, m, 0), 32'hF0402010, 32'hAAAAAAAA);
    for (int i = 0; i <= 32; i++)
      run_op("R5 mixed extract", pack(0, (4*i+19) % 33, (3*i+5) % 33), 32'hF0402010, 32'hAAAAAAAA);
    run_op("R6 insert mask0", pack(1, 0, 0), 32'hF0402010, 32'h2BAD2BAD);
    run_op("R6 insert mask32", pack(1, 32, 0), 32'hF0402010, 32'h2BAD2BAD);
    run_op("R6 insert shift32", pack(1, 32, 32), 32'hF0402010, 32'h2BAD2BAD);
    run_op("R6 insert m18 s4", pack(1, 18, 4), 32'hF0402010, 32'hAAAAAAAA);
    run_op("R6 insert m21 s12", pack(1, 21, 12), 32'hF0402010, 32'h2BAD2BAD);
    run_op("R2 field layout", 13'h1000 | 13'(9 << 6) | 13'd7, 32'h12345678, 32'h9ABCDEF0);
    run_op("R7 clamp shift", pack(0, 32, 63), 32'h11111111, 32'h5A5A5A5A);
    run_op("R7 clamp mask", pack(0, 50, 3), 32'h8421F0F0, 32'h0F0F1248);
    run_op("R7 clamp both insert", pack(1, 40, 45), 32'hCAFE0001, 32'h76543210);

    // R8: idle edges with changing operands leave result untouched
    held = result;
    for (int k = 0; k < 4; k++) begin
      left_op = ~left_op ^ 32'(k); right_op = right_op + 32'h01010101;
      @(negedge clk);
    end
    check("R8 hold", result, held);

    // R9: write and start on the same edge use the prior descriptor
    desc_we = 1'b1; desc_in = pack(0, 8, 4);
    @(negedge clk);
    desc_in = pack(1, 0, 0); start = 1'b1;
    left_op = 32'hDEADBEEF; right_op = 32'h0BADF00D;
    exp_q.push_back(model(pack(0, 8, 4), 32'hDEADBEEF, 32'h0BADF00D));
    tag_q.push_back("R9 old descriptor");
    @(negedge clk);
    desc_we = 1'b0;
    exp_q.push_back(32'h0BADF00D); tag_q.push_back("R9 new descriptor");
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);

    if (exp_q.size() != 0) check("R8 missing result", 32'(exp_q.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule